// File: doc/BRIEF.md
# Output Clock Gate and Power-Down Sequencer

This block sits between the clock sources of a system clock generator and the output pads. It takes the sources that the synthesizer produces (two host rates, memory, 66 MHz hub, PCI, 48 MHz and reference) and a test clock. From them it builds every gated output clock. A two-bit function select chooses the mode. In high impedance the pad enable is dropped. In test mode every output is a binary division of the test clock. In the two active modes the outputs follow their sources, and the host clock runs at either the lower or the higher rate.

All logic runs on a fast core clock `clk`. The source clocks are level signals that are synchronous to `clk` and change no faster than every other cycle. Each output is a registered copy of its selected source, gated by a per-lane gate bit. A gate bit may change only while its source is low, so an output never produces a shortened high pulse. Register enable bits stop single outputs. The free-running memory output and the reference output have no enable bit.

An asynchronous active-low power-down input is first synchronized. It is then qualified on two consecutive rising edges of the selected host clock. After that, every output stops low on its own next falling edge. When the input returns high, a programmable settle count stands in for the oscillator restart delay. Once it expires, the outputs resume on their next rising edges. The I/O-controller clock runs at half the PCI rate or at the full PCI rate, as chosen by a strap that is captured when reset is released.

Top module: `ck_outgate`

## Requirements
- R1: While `rst_n` is low, every clock output is 0 and `pad_oe` is 0.
- R2: `fsel` = 00 drives `pad_oe` to 0 one cycle later. Any other value drives it to 1 one cycle later.
- R3: With `fsel` = 10 the host outputs follow `cpu_lo_i`, and with `fsel` = 11 they follow `cpu_hi_i`. In both modes every other output follows its own source input one `clk` cycle later.
- R4: With `fsel` = 01, the outputs divide a counter that steps on each rising edge of `tclk_i`. Host and 48 MHz outputs run at tclk/2, memory and hub outputs at tclk/4, PCI at tclk/8, the I/O-controller clock at tclk/16, and the reference equals `tclk_i`.
- R5: The `en` bits are packed from bit 0 upward in this order: host (NCPU), memory (NSD), hub (NHUB), PCI (NPCI), I/O controller (NAPIC), 48 MHz (NUSB). An output whose bit is 0 stays low and does not toggle.
- R6: Any gating change takes effect only while the source is low. Every high pulse on an output therefore lasts the full high time of its source, even while enable bits toggle.
- R7: `sdram_free_o` and `ref_o` ignore `en` and run even when all enable bits are 0.
- R8: `apic_strap` is captured on the first cycle after reset is released. A 0 gives an I/O-controller clock of half the PCI rate, and a 1 gives the PCI rate. Later changes have no effect until the next reset.
- R9: Power-down is accepted only after the synchronized `pd_n` is seen low at two consecutive rising edges of the selected host clock. A shorter low pulse leaves the outputs running.
- R10: Once power-down is accepted, each output, including `sdram_free_o`, `ref_o` and the 48 MHz outputs, falls with its source and then stays low for as long as `pd_n` is low.
- R11: After `pd_n` rises, every output stays low for at least `settle_len` cycles. The outputs then resume with full-width pulses.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pd_n | input | 1 | Asynchronous active-low power-down request |
| fsel | input | 2 | Function select: 00 high-Z, 01 test, 10 low host rate, 11 high host rate |
| apic_strap | input | 1 | I/O-controller rate strap, captured after reset |
| settle_len | input | SW | Settle count after power-down release |
| en | input | NEN | Per-output enable bits (packing in R5) |
| cpu_lo_i | input | 1 | Host source, lower rate |
| cpu_hi_i | input | 1 | Host source, higher rate |
| sdram_i | input | 1 | Memory clock source |
| hub_i | input | 1 | 66 MHz hub source |
| pci_i | input | 1 | PCI source |
| usb_i | input | 1 | 48 MHz source |
| ref_i | input | 1 | Reference source |
| tclk_i | input | 1 | Test clock |
| cpu_o | output | NCPU | Host clock outputs |
| sdram_o | output | NSD | Gated memory clock outputs |
| sdram_free_o | output | 1 | Free-running memory clock |
| hub_o | output | NHUB | Hub clock outputs |
| pci_o | output | NPCI | PCI clock outputs |
| apic_o | output | NAPIC | I/O-controller clock outputs |
| usb_o | output | NUSB | 48 MHz outputs |
| ref_o | output | 1 | Reference output |
| pad_oe | output | 1 | Pad output enable; 0 means high impedance |

## Verification
Two functions can act on a lane in the same cycle. One is power-down acceptance. The other is a change of the lane's own enable bit, or the settle release. The bench flips the host enable bit repeatedly while power-down is taking hold, while it is held, and across the release. The result is judged at the ports. During power-down there must be no rising edge at all. Every high pulse seen in the windows around entry and exit must have exactly the source's full high width. Any window in which a lane restarts mid-pulse or is cut short shows up as a reduced minimum width.

// File: rtl/ck_pkg.sv
package ck_pkg;
  typedef enum logic [1:0] {
    MODE_HIZ  = 2'b00,
    MODE_TEST = 2'b01,
    MODE_SLOW = 2'b10,
    MODE_FAST = 2'b11
  } mode_e;

  typedef enum logic [1:0] {
    PD_RUN    = 2'd0,
    PD_DOWN   = 2'd1,
    PD_SETTLE = 2'd2
  } pd_state_e;
endpackage

// File: rtl/ck_testdiv.sv
module ck_testdiv #(
  parameter int TDW = 4
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           tclk_i,
  output logic [TDW-1:0] div_o
);
  logic           tclk_prev_q;
  logic [TDW-1:0] cnt_q, cnt_d;
  logic           step;

  assign step = tclk_i & ~tclk_prev_q;

  always_comb begin
    cnt_d = cnt_q;
    if (step) cnt_d = cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tclk_prev_q <= 1'b0;
      cnt_q       <= '0;
    end else begin
      tclk_prev_q <= tclk_i;
      cnt_q       <= cnt_d;
    end
  end

  assign div_o = cnt_q;
endmodule

// File: rtl/ck_pdseq.sv
module ck_pdseq
  import ck_pkg::*;
#(
  parameter int SW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          pd_n,
  input  logic          cpu_src,
  input  logic [SW-1:0] settle_len,
  output logic          stop_o,
  output logic          pd_sync_o
);
  logic [1:0]  sync_q;
  logic        cpu_prev_q;
  logic        low_q, low_d;
  pd_state_e   state_q, state_d;
  logic [SW-1:0] cnt_q, cnt_d;
  logic        pd_sync, cpu_rise;

  assign pd_sync  = sync_q[1];
  assign cpu_rise = cpu_src & ~cpu_prev_q;

  always_comb begin
    state_d = state_q;
    low_d   = low_q;
    cnt_d   = cnt_q;
    case (state_q)
      PD_RUN: begin
        if (cpu_rise) begin
          if (!pd_sync) begin
            if (low_q) begin
              state_d = PD_DOWN;
              low_d   = 1'b0;
            end else begin
              low_d = 1'b1;
            end
          end else begin
            low_d = 1'b0;
          end
        end
      end
      PD_DOWN: begin
        if (pd_sync) begin
          state_d = PD_SETTLE;
          cnt_d   = '0;
        end
      end
      PD_SETTLE: begin
        if (!pd_sync)                state_d = PD_DOWN;
        else if (cnt_q == settle_len) state_d = PD_RUN;
        else                          cnt_d   = cnt_q + 1'b1;
      end
      default: state_d = PD_RUN;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q     <= 2'b11;
      cpu_prev_q <= 1'b0;
      low_q      <= 1'b0;
      state_q    <= PD_RUN;
      cnt_q      <= '0;
    end else begin
      sync_q     <= {sync_q[0], pd_n};
      cpu_prev_q <= cpu_src;
      low_q      <= low_d;
      state_q    <= state_d;
      cnt_q      <= cnt_d;
    end
  end

  assign stop_o    = (state_q != PD_RUN);
  assign pd_sync_o = pd_sync;
endmodule

// File: rtl/ck_lane.sv
module ck_lane (
  input  logic clk,
  input  logic rst_n,
  input  logic src,
  input  logic want,
  output logic out_o
);
  logic gate_q, gate_d;
  logic out_q, out_d;

  always_comb begin
    gate_d = gate_q;
    if (!src) gate_d = want;
    out_d = src & gate_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      gate_q <= 1'b0;
      out_q  <= 1'b0;
    end else begin
      gate_q <= gate_d;
      out_q  <= out_d;
    end
  end

  assign out_o = out_q;
endmodule

// File: rtl/ck_outgate.sv
module ck_outgate
  import ck_pkg::*;
#(
  parameter int NCPU  = 3,
  parameter int NSD   = 8,
  parameter int NHUB  = 2,
  parameter int NPCI  = 7,
  parameter int NAPIC = 2,
  parameter int NUSB  = 2,
  parameter int SW    = 8,
  parameter int TDW   = 4,
  localparam int NEN  = NCPU + NSD + NHUB + NPCI + NAPIC + NUSB
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             pd_n,
  input  logic [1:0]       fsel,
  input  logic             apic_strap,
  input  logic [SW-1:0]    settle_len,
  input  logic [NEN-1:0]   en,
  input  logic             cpu_lo_i,
  input  logic             cpu_hi_i,
  input  logic             sdram_i,
  input  logic             hub_i,
  input  logic             pci_i,
  input  logic             usb_i,
  input  logic             ref_i,
  input  logic             tclk_i,
  output logic [NCPU-1:0]  cpu_o,
  output logic [NSD-1:0]   sdram_o,
  output logic             sdram_free_o,
  output logic [NHUB-1:0]  hub_o,
  output logic [NPCI-1:0]  pci_o,
  output logic [NAPIC-1:0] apic_o,
  output logic [NUSB-1:0]  usb_o,
  output logic             ref_o,
  output logic             pad_oe
);
  localparam int O_SD   = NCPU;
  localparam int O_HUB  = O_SD + NSD;
  localparam int O_PCI  = O_HUB + NHUB;
  localparam int O_APIC = O_PCI + NPCI;
  localparam int O_USB  = O_APIC + NAPIC;
  localparam int L_FREE = NEN;
  localparam int L_REF  = NEN + 1;
  localparam int NL     = NEN + 2;

  mode_e          mode;
  logic           test;
  logic [TDW-1:0] tdiv;
  logic           stop_w, pd_sync_w;
  logic           cpu_src, sd_src, hub_src, pci_src, apic_src, usb_src, ref_src;
  logic           pci_prev_q, half_q, half_d;
  logic           strap_q, strap_d, taken_q, taken_d;
  logic           oe_q, oe_d;
  logic [NL-1:0]  lane_src, lane_want, lane_out;

  assign mode = mode_e'(fsel);
  assign test = (mode == MODE_TEST);

  ck_testdiv #(.TDW(TDW)) u_tdiv (
    .clk(clk), .rst_n(rst_n), .tclk_i(tclk_i), .div_o(tdiv)
  );

  ck_pdseq #(.SW(SW)) u_pd (
    .clk(clk), .rst_n(rst_n), .pd_n(pd_n), .cpu_src(cpu_src),
    .settle_len(settle_len), .stop_o(stop_w), .pd_sync_o(pd_sync_w)
  );

  // Source selection per output class
  always_comb begin
    cpu_src  = test ? tdiv[0] : (fsel[0] ? cpu_hi_i : cpu_lo_i);
    sd_src   = test ? tdiv[1] : sdram_i;
    hub_src  = test ? tdiv[1] : hub_i;
    pci_src  = test ? tdiv[2] : pci_i;
    apic_src = test ? tdiv[3] : (strap_q ? pci_i : half_q);
    usb_src  = test ? tdiv[0] : usb_i;
    ref_src  = test ? tclk_i  : ref_i;
  end

  // Half-rate divider, strap capture and pad enable
  always_comb begin
    half_d  = half_q;
    if (pci_i && !pci_prev_q) half_d = ~half_q;
    strap_d = strap_q;
    taken_d = taken_q;
    if (!taken_q) begin
      strap_d = apic_strap;
      taken_d = 1'b1;
    end
    oe_d = (mode != MODE_HIZ);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pci_prev_q <= 1'b0;
      half_q     <= 1'b0;
      strap_q    <= 1'b0;
      taken_q    <= 1'b0;
      oe_q       <= 1'b0;
    end else begin
      pci_prev_q <= pci_i;
      half_q     <= half_d;
      strap_q    <= strap_d;
      taken_q    <= taken_d;
      oe_q       <= oe_d;
    end
  end

  // Lane source and request mapping
  always_comb begin
    for (int i = 0; i < NEN; i++) begin
      if (i < O_SD)        lane_src[i] = cpu_src;
      else if (i < O_HUB)  lane_src[i] = sd_src;
      else if (i < O_PCI)  lane_src[i] = hub_src;
      else if (i < O_APIC) lane_src[i] = pci_src;
      else if (i < O_USB)  lane_src[i] = apic_src;
      else                 lane_src[i] = usb_src;
      lane_want[i] = en[i] & ~stop_w;
    end
    lane_src[L_FREE]  = sd_src;
    lane_want[L_FREE] = ~stop_w;
    lane_src[L_REF]   = ref_src;
    lane_want[L_REF]  = ~stop_w;
  end

  for (genvar g = 0; g < NL; g++) begin : g_lane
    ck_lane u_lane (
      .clk(clk), .rst_n(rst_n), .src(lane_src[g]),
      .want(lane_want[g]), .out_o(lane_out[g])
    );
  end

  assign cpu_o        = lane_out[0 +: NCPU];
  assign sdram_o      = lane_out[O_SD +: NSD];
  assign hub_o        = lane_out[O_HUB +: NHUB];
  assign pci_o        = lane_out[O_PCI +: NPCI];
  assign apic_o       = lane_out[O_APIC +: NAPIC];
  assign usb_o        = lane_out[O_USB +: NUSB];
  assign sdram_free_o = lane_out[L_FREE];
  assign ref_o        = lane_out[L_REF];
  assign pad_oe       = oe_q;
endmodule

// File: rtl/ck_outgate_chk.sv
module ck_outgate_chk (
  input logic       clk,
  input logic       rst_n,
  input logic [1:0] fsel,
  input logic       en0,
  input logic       stop,
  input logic       pd_sync,
  input logic       pad_oe,
  input logic       ref_o,
  input logic       cpu0
);
  // R2: high-impedance select drops the pad enable one cycle later
  p_tristate_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (fsel == 2'b00) |=> !pad_oe);

  // R5: a lane held disabled and already low never rises
  p_disabled_low_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (!en0 && $past(!en0) && !cpu0) |=> !cpu0);

  // R9: stop is raised only after the synchronized request was low
  p_qualify_r9: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(stop) |-> !$past(pd_sync));

  // R10: once stopped and low, the reference output stays low
  p_stop_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (stop && $past(stop) && !ref_o) |=> !ref_o);
endmodule

bind ck_outgate ck_outgate_chk u_chk (
  .clk(clk), .rst_n(rst_n), .fsel(fsel), .en0(en[0]), .stop(stop_w),
  .pd_sync(pd_sync_w), .pad_oe(pad_oe), .ref_o(ref_o), .cpu0(cpu_o[0])
);

// File: tb/sim_ck_outgate.sv
`timescale 1ns/1ps
module sim_ck_outgate;
  localparam int NEN = 24;

  logic clk = 1'b0;
  logic rst_n, pd_n, apic_strap;
  logic [1:0] fsel;
  logic [7:0] settle_len;
  logic [NEN-1:0] en;
  logic [2:0] cpu_o;
  logic [7:0] sdram_o;
  logic sdram_free_o, ref_o, pad_oe;
  logic [1:0] hub_o, apic_o, usb_o;
  logic [6:0] pci_o;

  int cyc = 0;
  logic cpu_lo_i, cpu_hi_i, sdram_i, hub_i, pci_i, usb_i, ref_i, tclk_i;
  assign cpu_lo_i = (cyc % 6)  < 3;
  assign cpu_hi_i = (cyc % 4)  < 2;
  assign sdram_i  = (cyc % 8)  < 4;
  assign hub_i    = (cyc % 6)  < 3;
  assign pci_i    = (cyc % 12) < 6;
  assign usb_i    = (cyc % 10) < 5;
  assign ref_i    = (cyc % 14) < 7;
  assign tclk_i   = (cyc % 4)  < 2;

  always #4 clk = ~clk;
  always @(negedge clk) cyc <= cyc + 1;

  ck_outgate u0 (
    .clk(clk), .rst_n(rst_n), .pd_n(pd_n), .fsel(fsel), .apic_strap(apic_strap),
    .settle_len(settle_len), .en(en), .cpu_lo_i(cpu_lo_i), .cpu_hi_i(cpu_hi_i),
    .sdram_i(sdram_i), .hub_i(hub_i), .pci_i(pci_i), .usb_i(usb_i), .ref_i(ref_i),
    .tclk_i(tclk_i), .cpu_o(cpu_o), .sdram_o(sdram_o), .sdram_free_o(sdram_free_o),
    .hub_o(hub_o), .pci_o(pci_o), .apic_o(apic_o), .usb_o(usb_o), .ref_o(ref_o),
    .pad_oe(pad_oe)
  );

  // Observed: 0 cpu,1 sdram,2 free,3 hub,4 pci,5 apic,6 usb,7 ref
  logic [7:0] obs;
  assign obs = {ref_o, usb_o[0], apic_o[0], pci_o[1], hub_o[0], sdram_free_o, sdram_o[0], cpu_o[0]};
  string nm [8] = '{"cpu", "sdram", "free", "hub", "pci", "apic", "usb", "ref"};

  int rises [8];
  int minw  [8];
  int run   [8];
  bit armed [8];
  bit valid [8];
  bit prv   [8];
  bit clr = 1'b0;

  always @(negedge clk) begin
    for (int i = 0; i < 8; i++) begin
      if (clr) begin
        rises[i] = 0; minw[i] = 255; run[i] = 0;
        armed[i] = 1'b0; valid[i] = 1'b0; prv[i] = obs[i];
      end else begin
        if (obs[i] && !prv[i]) begin
          rises[i] = rises[i] + 1; run[i] = 1; valid[i] = armed[i];
        end else if (obs[i]) begin
          run[i] = run[i] + 1;
        end else begin
          if (prv[i] && valid[i] && run[i] < minw[i]) minw[i] = run[i];
          armed[i] = 1'b1;
        end
        prv[i] = obs[i];
      end
    end
  end

  int total = 0;
  int bad   = 0;

  task automatic chk_eq(string tag, int act, int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s act=%0d exp=%0d", tag, act, exp);
    end
  endtask

  task automatic chk_near(string tag, int act, int exp);
    total++;
    if (act > exp + 1 || act < exp - 1) begin
      bad++;
      $display("FAIL %s act=%0d exp=%0d (+/-1)", tag, act, exp);
    end
  endtask

  task automatic win(int n);
    @(posedge clk); clr = 1'b1;
    @(posedge clk); clr = 1'b0;
    repeat (n) @(negedge clk);
  endtask

  task automatic do_reset(bit strap);
    @(negedge clk);
    rst_n = 1'b0; apic_strap = strap;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
  endtask

  // R1: reset state
  task automatic t_reset_state();
    @(negedge clk);
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    chk_eq("R1 outputs in reset", int'({cpu_o, sdram_o, sdram_free_o, hub_o, pci_o, apic_o, usb_o, ref_o} != 0), 0);
    chk_eq("R1 pad_oe in reset", int'(pad_oe), 0);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
  endtask

  // R2: pad enable per mode
  task automatic t_tristate();
    @(negedge clk); fsel = 2'b00;
    repeat (2) @(negedge clk);
    chk_eq("R2 pad_oe at 00", int'(pad_oe), 0);
    fsel = 2'b10;
    repeat (2) @(negedge clk);
    chk_eq("R2 pad_oe at 10", int'(pad_oe), 1);
  endtask

  // R3: active modes
  task automatic t_active();
    @(negedge clk); fsel = 2'b10;
    repeat (20) @(negedge clk);
    win(480);
    chk_near("R3 cpu slow", rises[0], 80);
    chk_near("R3 sdram", rises[1], 60);
    chk_near("R3 hub", rises[3], 80);
    chk_near("R3 pci", rises[4], 40);
    chk_near("R3 usb", rises[6], 48);
    chk_near("R3 ref", rises[7], 34);
    chk_near("R8 apic strap1 full rate", rises[5], 40);
    @(negedge clk); fsel = 2'b11;
    repeat (20) @(negedge clk);
    win(480);
    chk_near("R3 cpu fast", rises[0], 120);
    @(negedge clk); fsel = 2'b10;
    repeat (20) @(negedge clk);
  endtask

  // R4: test mode divisions
  task automatic t_test();
    @(negedge clk); fsel = 2'b01;
    repeat (80) @(negedge clk);
    win(480);
    chk_near("R4 cpu tclk/2", rises[0], 60);
    chk_near("R4 sdram tclk/4", rises[1], 30);
    chk_near("R4 free tclk/4", rises[2], 30);
    chk_near("R4 hub tclk/4", rises[3], 30);
    chk_near("R4 pci tclk/8", rises[4], 15);
    chk_near("R4 apic tclk/16", rises[5], 8);
    chk_near("R4 usb tclk/2", rises[6], 60);
    chk_near("R4 ref tclk", rises[7], 120);
    @(negedge clk); fsel = 2'b10;
    repeat (20) @(negedge clk);
  endtask

  // R5, R6: enable gating
  task automatic t_enable();
    @(negedge clk); en = '1; en[0] = 1'b0;
    repeat (12) @(negedge clk);
    win(240);
    chk_eq("R5 disabled cpu0 rises", rises[0], 0);
    chk_eq("R5 disabled cpu0 level", int'(cpu_o[0]), 0);
    chk_eq("R5 cpu1 still runs", int'(cpu_o[1] || rises[0] == 0), 1);
    chk_near("R5 sdram0 unaffected", rises[1], 30);
    @(posedge clk); clr = 1'b1;
    @(posedge clk); clr = 1'b0;
    for (int k = 0; k < 40; k++) begin
      @(negedge clk); en[0] = ~en[0];
      repeat ((k % 7) + 2) @(negedge clk);
    end
    en = '1;
    repeat (30) @(negedge clk);
    chk_eq("R6 cpu0 min high width under toggling", minw[0], 3);
  endtask

  // R7: free-running outputs ignore enables
  task automatic t_free();
    @(negedge clk); en = '0;
    repeat (20) @(negedge clk);
    win(480);
    chk_near("R7 free sdram runs", rises[2], 60);
    chk_near("R7 ref runs", rises[7], 34);
    chk_eq("R5 sdram0 off", rises[1], 0);
    chk_eq("R5 usb0 off", rises[6], 0);
    chk_eq("R5 apic0 off", rises[5], 0);
    @(negedge clk); en = '1;
    repeat (20) @(negedge clk);
  endtask

  // R9: short request is rejected
  task automatic t_pd_short();
    @(posedge clk); clr = 1'b1;
    @(posedge clk); clr = 1'b0;
    repeat (50) @(negedge clk);
    pd_n = 1'b0;
    repeat (3) @(negedge clk);
    pd_n = 1'b1;
    repeat (427) @(negedge clk);
    chk_near("R9 short pulse cpu keeps running", rises[0], 80);
    chk_near("R9 short pulse ref keeps running", rises[7], 34);
  endtask

  // R10, R11: full sequence with enable activity
  task automatic t_pd_full();
    int expw [8] = '{3, 4, 4, 3, 6, 6, 5, 7};
    @(negedge clk); settle_len = 8'd40;
    @(posedge clk); clr = 1'b1;
    @(posedge clk); clr = 1'b0;
    repeat (60) @(negedge clk);
    pd_n = 1'b0;
    for (int k = 0; k < 20; k++) begin
      @(negedge clk); en[0] = ~en[0];
    end
    en[0] = 1'b1;
    repeat (40) @(negedge clk);
    for (int i = 0; i < 8; i++) chk_eq({"R10 full width on entry ", nm[i]}, minw[i], expw[i]);
    @(posedge clk); clr = 1'b1;
    @(posedge clk); clr = 1'b0;
    for (int k = 0; k < 100; k++) begin
      @(negedge clk);
      if (k % 9 == 0) en[0] = ~en[0];
    end
    en[0] = 1'b1;
    chk_eq("R10 no rises while down", rises[0] + rises[1] + rises[2] + rises[3] + rises[4] + rises[5] + rises[6] + rises[7], 0);
    chk_eq("R10 all low while down", int'(obs), 0);
    @(posedge clk); clr = 1'b1;
    @(posedge clk); clr = 1'b0;
    @(negedge clk); pd_n = 1'b1;
    repeat (40) @(negedge clk);
    chk_eq("R11 still low during settle", rises[0] + rises[2] + rises[7], 0);
    repeat (60) @(negedge clk);
    for (int i = 0; i < 8; i++) chk_eq({"R11 full width on resume ", nm[i]}, minw[i], expw[i]);
    win(480);
    chk_near("R11 cpu resumed rate", rises[0], 80);
    chk_near("R11 ref resumed rate", rises[7], 34);
  endtask

  // R8: strap capture
  task automatic t_strap();
    do_reset(1'b0);
    repeat (20) @(negedge clk);
    win(480);
    chk_near("R8 strap0 half rate", rises[5], 20);
    @(negedge clk); apic_strap = 1'b1;
    repeat (20) @(negedge clk);
    win(480);
    chk_near("R8 strap change ignored", rises[5], 20);
    do_reset(1'b1);
    repeat (20) @(negedge clk);
    win(480);
    chk_near("R8 strap1 after reset", rises[5], 40);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    bad++;
    $display("FAIL watchdog act=timeout exp=finish");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    rst_n = 1'b0; pd_n = 1'b1; fsel = 2'b10; apic_strap = 1'b1;
    settle_len = 8'd40; en = '1;
    t_reset_state();
    do_reset(1'b1);
    t_tristate();
    t_active();
    t_test();
    t_enable();
    t_free();
    t_pd_short();
    t_pd_full();
    t_strap();
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule